// File: doc/BRIEF.md
# Debug Request to AHB-Lite Transfer Master

This block sits between a debug access port and a system bus. The debug side hands it one read or write request at a time: an address, write data, a transfer size, a direction, a five-bit protection field and a secure-request bit. The block turns the request into AHB-Lite traffic and answers with a one-cycle completion pulse, an error flag and the read data. Each bus transfer it starts is a lone NONSEQ transfer with a SINGLE burst code. The byte-lane strobes are derived from the size and the low address bits, so the requester never sets them.

Three gating inputs decide whether a request may reach the bus at all: a debug-enable, a secure-enable and a system power-down indication. A request is also refused if its size is wider than the data bus or its address is not aligned to its size. A refused request produces no bus cycle and completes locally with the error flag set. A packed request carries several byte or halfword units in one data word. The block issues it as a run of separate single transfers at consecutive addresses and stops at the first unit that returns an error.

Top module: `dbg_bus_master`

## Requirements
- R1: `req_ready` is high only while no request is in flight. A request is taken when `req_valid` is high while `req_ready` is high. Each taken request yields exactly one single-cycle `req_done` pulse, and `req_err` and `req_rdata` are valid in that cycle.
- R2: A request taken while `dbg_en` is low starts no bus transfer. It completes with `req_err` high on the clock after acceptance.
- R3: A request taken while `sys_pwr_down` is high starts no bus transfer. It completes with `req_err` high on the clock after acceptance.
- R4: A request with `req_secure` high taken while `sec_en` is low starts no bus transfer and completes with an error. Otherwise `hprot[6]` is driven as the inverse of `req_secure`, so 1 means nonsecure and 0 means secure.
- R5: `hprot[4:0]` equals `req_prot` for every transfer of a request, and `hprot[5]` is always 0.
- R6: `hsize` codes are 0 for byte, 1 for halfword and 2 for word. `hbstrb` bit i is set exactly when byte lane i lies within the unit addressed by `haddr`. For example, a byte at offset 0 gives 0001, a byte at offset 3 gives 1000, a halfword at offset 2 gives 1100 and a word gives 1111.
- R7: A request with `req_size` of 3 or more, or with address bits below the unit size not zero, is rejected with an error and starts no bus transfer.
- R8: `htrans` is 2'b10 (NONSEQ) only during an address phase and 2'b00 (IDLE) at all other times. `hburst` is always 3'b000 (SINGLE). The address phase, including `haddr`, is held while `hready` is low.
- R9: Write data is driven on `hwdata` in the data phase and held until `hready` is high. Read data is captured when `hready` is high, for only the lanes enabled by `hbstrb`. `req_rdata` lanes that no transfer captured read as 0, and a write returns 0.
- R10: Any `hresp` value other than 2'b00 at the end of a data phase makes the request complete with `req_err` high.
- R11: A packed request (`req_pack` high) of byte or halfword size must start at an address with the lane-offset bits zero, otherwise it is rejected. It issues (bus bytes / unit bytes) single transfers at increasing consecutive addresses and assembles all read lanes into `req_rdata`. It stops after the first unit that returns an error. A packed word request is one transfer.
- R12: `hsize` equals the request size and `hwrite` equals `req_write` for every transfer of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, can take a request |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Request write data, on the lanes of the address |
| req_size | input | 3 | Unit size: 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_pack | input | 1 | Issue every byte/halfword unit of the word |
| req_prot | input | 5 | Protection bits for hprot[4:0] |
| req_secure | input | 1 | Request a secure transfer |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Request failed, valid with req_done |
| req_rdata | output | DATA_W | Read data, valid with req_done |
| dbg_en | input | 1 | Debug enable, bus transfers allowed when high |
| sec_en | input | 1 | Secure transfers allowed when high |
| sys_pwr_down | input | 1 | System bus domain powered down |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Transfer type, IDLE or NONSEQ |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type, always SINGLE |
| hprot | output | 7 | Protection, bit 6 high for nonsecure |
| hbstrb | output | DATA_W/8 | Byte-lane strobes |
| hwrite | output | 1 | Transfer direction |
| hwdata | output | DATA_W | Write data |
| hready | input | 1 | Bus transfer ready |
| hrdata | input | DATA_W | Bus read data |
| hresp | input | 2 | Bus response, non-zero is an error |

## Verification
The bench builds the block with ADDR_W = 16 and DATA_W = 32, which gives four byte lanes and two offset bits. Every strobe pattern, every misalignment, packed runs of four bytes or two halfwords, and the wider-than-bus size code 3 are therefore all reachable. The small address space lets a slave model keep sixteen words and report errors, with a randomly chosen non-zero response code, for addresses that have bit 6 set. This exercises failing units inside packed runs as well as single transfers. Random wait states of up to three cycles test the phase-holding rules, and a random mix of the three gate inputs reaches every rejection path.

// File: rtl/dbg_bus_pkg.sv
package dbg_bus_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_NONSEQ = 2'b10
  } trans_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA
  } state_e;

  localparam logic [2:0] BURST_SINGLE = 3'b000;

endpackage

// File: rtl/dbg_lane_strobe.sv
// Byte-lane strobe decode from unit size and address offset.
module dbg_lane_strobe #(
  parameter  int STRB_W = 4,
  localparam int OFF_W  = $clog2(STRB_W)
) (
  input  logic [2:0]        size,
  input  logic [OFF_W-1:0]  offset,
  output logic [STRB_W-1:0] strb,
  output logic              size_ok,
  output logic              aligned
);

  assign size_ok = (int'(size) <= OFF_W);

  always_comb begin
    aligned = 1'b1;
    for (int b = 0; b < OFF_W; b++) begin
      if ((b < int'(size)) && offset[b]) aligned = 1'b0;
    end
  end

  for (genvar i = 0; i < STRB_W; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE = OFF_W'(i);
    assign strb[i] = size_ok && ((LANE >> size) == (offset >> size));
  end

endmodule

// File: rtl/dbg_xfer_gate.sv
// Decides whether a request may reach the bus.
module dbg_xfer_gate #(
  parameter int OFF_W = 2
) (
  input  logic             dbg_en,
  input  logic             sys_pwr_down,
  input  logic             sec_en,
  input  logic             req_secure,
  input  logic             req_pack,
  input  logic [2:0]       size,
  input  logic [OFF_W-1:0] offset,
  input  logic             size_ok,
  input  logic             aligned,
  output logic             blocked
);

  logic pack_bad;
  logic sec_bad;

  assign pack_bad = req_pack && (int'(size) < OFF_W) && (offset != '0);
  assign sec_bad  = req_secure && !sec_en;
  assign blocked  = !dbg_en || sys_pwr_down || sec_bad || !size_ok ||
                    !aligned || pack_bad;

endmodule

// File: rtl/dbg_bus_master.sv
module dbg_bus_master
  import dbg_bus_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8,
  localparam int OFF_W  = $clog2(STRB_W),
  localparam int CNT_W  = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [2:0]        req_size,
  input  logic              req_write,
  input  logic              req_pack,
  input  logic [4:0]        req_prot,
  input  logic              req_secure,
  output logic              req_done,
  output logic              req_err,
  output logic [DATA_W-1:0] req_rdata,
  input  logic              dbg_en,
  input  logic              sec_en,
  input  logic              sys_pwr_down,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [6:0]        hprot,
  output logic [STRB_W-1:0] hbstrb,
  output logic              hwrite,
  output logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic [DATA_W-1:0] hrdata,
  input  logic [1:0]        hresp
);

  state_e              state_q;
  trans_e              htrans_q;
  logic [ADDR_W-1:0]   haddr_q;
  logic [2:0]          hsize_q;
  logic [6:0]          hprot_q;
  logic [STRB_W-1:0]   hbstrb_q;
  logic                hwrite_q;
  logic [DATA_W-1:0]   hwdata_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [CNT_W-1:0]    units_q;
  logic                done_q;
  logic                err_q;
  logic [DATA_W-1:0]   rdata_q;

  logic [STRB_W-1:0]   acc_strb;
  logic                size_ok;
  logic                aligned;
  logic                blocked;
  logic [CNT_W-1:0]    units_req;
  logic [OFF_W:0]      unit_bytes;
  logic [ADDR_W-1:0]   addr_nxt;
  logic [STRB_W-1:0]   strb_nxt;

  dbg_lane_strobe #(.STRB_W(STRB_W)) u_strb (
    .size    (req_size),
    .offset  (req_addr[OFF_W-1:0]),
    .strb    (acc_strb),
    .size_ok (size_ok),
    .aligned (aligned)
  );

  dbg_xfer_gate #(.OFF_W(OFF_W)) u_gate (
    .dbg_en       (dbg_en),
    .sys_pwr_down (sys_pwr_down),
    .sec_en       (sec_en),
    .req_secure   (req_secure),
    .req_pack     (req_pack),
    .size         (req_size),
    .offset       (req_addr[OFF_W-1:0]),
    .size_ok      (size_ok),
    .aligned      (aligned),
    .blocked      (blocked)
  );

  // Remaining units after the first one of a packed request.
  always_comb begin
    units_req = '0;
    if (req_pack && (int'(req_size) < OFF_W))
      units_req = CNT_W'((STRB_W >> req_size) - 1);
  end

  // Step to the next unit of a packed run.
  assign unit_bytes = (OFF_W+1)'(1) << hsize_q;
  assign addr_nxt   = haddr_q + ADDR_W'(unit_bytes);
  assign strb_nxt   = hbstrb_q << unit_bytes;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      htrans_q <= TR_IDLE;
      haddr_q  <= '0;
      hsize_q  <= '0;
      hprot_q  <= '0;
      hbstrb_q <= '0;
      hwrite_q <= 1'b0;
      hwdata_q <= '0;
      wdata_q  <= '0;
      units_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
            if (blocked) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              state_q  <= ST_ADDR;
              htrans_q <= TR_NONSEQ;
              haddr_q  <= req_addr;
              hsize_q  <= req_size;
              hprot_q  <= {~req_secure, 1'b0, req_prot};
              hbstrb_q <= acc_strb;
              hwrite_q <= req_write;
              wdata_q  <= req_wdata;
              units_q  <= units_req;
            end
          end
        end
        ST_ADDR: begin
          if (hready) begin
            state_q  <= ST_DATA;
            htrans_q <= TR_IDLE;
            hwdata_q <= wdata_q;
          end
        end
        ST_DATA: begin
          if (hready) begin
            if (hresp != 2'b00) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
            end else begin
              if (!hwrite_q) begin
                for (int i = 0; i < STRB_W; i++) begin
                  if (hbstrb_q[i]) rdata_q[8*i +: 8] <= hrdata[8*i +: 8];
                end
              end
              if (units_q != '0) begin
                units_q  <= units_q - 1'b1;
                haddr_q  <= addr_nxt;
                hbstrb_q <= strb_nxt;
                htrans_q <= TR_NONSEQ;
                state_q  <= ST_ADDR;
              end else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign req_done  = done_q;
  assign req_err   = err_q;
  assign req_rdata = rdata_q;
  assign haddr     = haddr_q;
  assign htrans    = htrans_q;
  assign hsize     = hsize_q;
  assign hburst    = BURST_SINGLE;
  assign hprot     = hprot_q;
  assign hbstrb    = hbstrb_q;
  assign hwrite    = hwrite_q;
  assign hwdata    = hwdata_q;

endmodule

// File: rtl/dbg_bus_master_chk.sv
module dbg_bus_master_chk #(
  parameter int ADDR_W = 32,
  parameter int STRB_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [4:0]        req_prot,
  input logic              req_secure,
  input logic              req_done,
  input logic              req_err,
  input logic              dbg_en,
  input logic              sec_en,
  input logic              sys_pwr_down,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic [2:0]        hsize,
  input logic [6:0]        hprot,
  input logic [STRB_W-1:0] hbstrb,
  input logic              hready
);

  logic take;
  assign take = req_valid && req_ready;

  // R1
  busy_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b10) |-> !req_ready);

  // R1
  done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_done |-> req_ready);

  // R2
  dbg_off_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !dbg_en) |=> (req_done && req_err && htrans == 2'b00));

  // R3
  pwr_down_chk: assert property (@(posedge clk) disable iff (rst)
    (take && sys_pwr_down) |=> (req_done && req_err && htrans == 2'b00));

  // R4
  secure_block_chk: assert property (@(posedge clk) disable iff (rst)
    (take && req_secure && !sec_en) |=> (req_done && req_err && htrans == 2'b00));

  // R5
  prot_map_chk: assert property (@(posedge clk) disable iff (rst)
    (take && dbg_en && !sys_pwr_down) |=>
      (req_done || hprot == {!$past(req_secure), 1'b0, $past(req_prot)}));

  // R6
  strb_count_chk: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b10) |-> ($countones(hbstrb) == (1 << hsize)));

  // R8
  trans_code_chk: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b00) || (htrans == 2'b10));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b10 && !hready) |=> (htrans == 2'b10 && $stable(haddr)));

endmodule

bind dbg_bus_master dbg_bus_master_chk #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_chk (.*);

// File: tb/dbg_bus_master_bench.sv
module dbg_bus_master_bench;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [2:0]    req_size = '0;
  logic          req_write = 1'b0;
  logic          req_pack = 1'b0;
  logic [4:0]    req_prot = '0;
  logic          req_secure = 1'b0;
  logic          req_done;
  logic          req_err;
  logic [DW-1:0] req_rdata;
  logic          dbg_en = 1'b1;
  logic          sec_en = 1'b1;
  logic          sys_pwr_down = 1'b0;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic [2:0]    hsize;
  logic [2:0]    hburst;
  logic [6:0]    hprot;
  logic [SW-1:0] hbstrb;
  logic          hwrite;
  logic [DW-1:0] hwdata;
  logic          hready;
  logic [DW-1:0] hrdata;
  logic [1:0]    hresp;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dbg_bus_master #(.ADDR_W(AW), .DATA_W(DW)) u_dbg_bus_master (.*);

  // ---------------- slave model ----------------
  logic [DW-1:0] mem [16];
  logic [DW-1:0] ref_mem [16];
  logic          dp_act, dp_wr, dp_err;
  logic [1:0]    dp_code;
  logic [SW-1:0] dp_strb;
  logic [3:0]    dp_idx;
  int            dp_wait;
  int            max_wait = 0;
  int            nxf;
  logic [SW-1:0] last_strb;
  logic [6:0]    last_prot;
  logic [2:0]    last_size;
  logic [2:0]    last_burst;
  logic          last_wr;

  function automatic logic [DW-1:0] init_word(int i);
    return (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0F96;
  endfunction

  assign hready = !dp_act || dp_wait == 0;
  assign hresp  = (dp_act && dp_err && dp_wait == 0) ? dp_code : 2'b00;
  assign hrdata = (dp_act && !dp_wr && dp_wait == 0) ? mem[dp_idx] : 32'hDEAD_BEEF;

  always @(posedge clk) begin
    if (rst) begin
      dp_act <= 1'b0; dp_wr <= 1'b0; dp_err <= 1'b0; dp_code <= 2'b01;
      dp_strb <= '0; dp_idx <= '0; dp_wait <= 0; nxf <= 0;
      last_strb <= '0; last_prot <= '0; last_size <= '0; last_burst <= '0; last_wr <= 1'b0;
      for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
    end else if (dp_act && dp_wait != 0) begin
      dp_wait <= dp_wait - 1;
    end else begin
      if (dp_act && dp_wr && !dp_err)
        for (int i = 0; i < SW; i++)
          if (dp_strb[i]) mem[dp_idx][8*i +: 8] <= hwdata[8*i +: 8];
      dp_act  <= (htrans == 2'b10);
      dp_wr   <= hwrite;
      dp_err  <= haddr[6];
      dp_code <= 2'(1 + ($urandom % 3));
      dp_idx  <= haddr[5:2];
      dp_strb <= hbstrb;
      dp_wait <= (max_wait > 0) ? int'($urandom % (max_wait + 1)) : 0;
      if (htrans == 2'b10) begin
        nxf        <= nxf + 1;
        last_strb  <= hbstrb;
        last_prot  <= hprot;
        last_size  <= hsize;
        last_burst <= hburst;
        last_wr    <= hwrite;
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] exp_strb(input logic [2:0] size, input logic [1:0] off);
    case (size)
      3'd0:    return SW'(1) << off;
      3'd1:    return off[1] ? 4'b1100 : 4'b0011;
      3'd2:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [SW-1:0] s);
    logic [DW-1:0] m = '0;
    for (int i = 0; i < SW; i++) if (s[i]) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic run_req(input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [2:0] sz, input bit wr, input bit pk,
                         input logic [4:0] pr, input bit sec, input bit en,
                         input bit pd, input bit sen, input string tag);
    bit blocked, mis, bus_err, exp_err;
    int units, exp_xf, start_xf, lat;
    logic [SW-1:0] smask, fin_strb;
    logic [DW-1:0] exp_rd;
    mis = 1'b0;
    if (sz == 3'd1 && a[0]) mis = 1'b1;
    if (sz == 3'd2 && a[1:0] != 2'b00) mis = 1'b1;
    if (pk && sz < 3'd2 && a[1:0] != 2'b00) mis = 1'b1;
    blocked = !en || pd || (sec && !sen) || (sz > 3'd2) || mis;
    units   = (pk && sz < 3'd2) ? (4 >> sz) : 1;
    bus_err = a[6];
    exp_err = blocked || bus_err;
    exp_xf  = blocked ? 0 : (bus_err ? 1 : units);
    smask   = (pk && sz < 3'd2) ? 4'b1111 : exp_strb(sz, a[1:0]);
    fin_strb = (pk && sz < 3'd2) ? ((sz == 3'd0) ? 4'b1000 : 4'b1100) : exp_strb(sz, a[1:0]);
    exp_rd  = (exp_err || wr) ? '0 : (ref_mem[a[5:2]] & lane_mask(smask));

    @(negedge clk);
    req_addr = a; req_wdata = wd; req_size = sz; req_write = wr; req_pack = pk;
    req_prot = pr; req_secure = sec; dbg_en = en; sys_pwr_down = pd; sec_en = sen;
    start_xf = nxf;
    chk(req_ready == 1'b1, "R1", {tag, " ready before request"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!req_done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(req_done == 1'b1, "R1", {tag, " done pulse"}, 32'(req_done), 32'd1);
    chk(req_err == exp_err, exp_err ? (blocked ? "R7" : "R10") : "R1",
        {tag, " error flag"}, 32'(req_err), 32'(exp_err));
    chk(req_rdata == exp_rd, pk ? "R11" : "R9", {tag, " read data"}, req_rdata, exp_rd);
    chk((nxf - start_xf) == exp_xf, pk ? "R11" : "R8", {tag, " bus transfer count"},
        32'(nxf - start_xf), 32'(exp_xf));
    if (blocked)
      chk(lat == 1, !en ? "R2" : (pd ? "R3" : "R7"), {tag, " local reject latency"},
          32'(lat), 32'd1);
    if (exp_xf > 0) begin
      chk(last_prot == {~sec, 1'b0, pr}, "R5", {tag, " hprot"}, 32'(last_prot),
          32'({~sec, 1'b0, pr}));
      chk(last_strb == (bus_err ? exp_strb(sz, a[1:0]) : fin_strb), "R6",
          {tag, " hbstrb"}, 32'(last_strb), 32'(bus_err ? exp_strb(sz, a[1:0]) : fin_strb));
      chk(last_size == sz && last_wr == wr, "R12", {tag, " hsize/hwrite"},
          32'({last_wr, last_size}), 32'({wr, sz}));
      chk(last_burst == 3'b000, "R8", {tag, " hburst"}, 32'(last_burst), 32'd0);
    end
    @(negedge clk);
    chk(req_done == 1'b0 && htrans == 2'b00, "R1", {tag, " done is one cycle"},
        32'({req_done, htrans}), 32'd0);
    if (wr && !exp_err)
      ref_mem[a[5:2]] = (ref_mem[a[5:2]] & ~lane_mask(smask)) | (wd & lane_mask(smask));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) ref_mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 R8 reset state
    chk(req_ready && !req_done && htrans == 2'b00 && hburst == 3'b000, "R1",
        "reset state", 32'({req_ready, req_done, htrans, hburst}), 32'({1'b1, 1'b0, 2'b00, 3'b000}));

    // R6 strobe shapes, R9 write then read
    run_req(16'h0000, 32'h0000_00AB, 3'd0, 1, 0, 5'h03, 0, 1, 0, 1, "R6 byte off0 wr");
    run_req(16'h0003, 32'hCD00_0000, 3'd0, 1, 0, 5'h01, 0, 1, 0, 1, "R6 byte off3 wr");
    run_req(16'h0002, 32'h1234_0000, 3'd1, 1, 0, 5'h1F, 0, 1, 0, 1, "R6 half off2 wr");
    run_req(16'h0004, 32'hCAFE_F00D, 3'd2, 1, 0, 5'h00, 0, 1, 0, 1, "R6 word wr");
    run_req(16'h0000, 32'h0, 3'd2, 0, 0, 5'h02, 0, 1, 0, 1, "R9 word rd");
    run_req(16'h0003, 32'h0, 3'd0, 0, 0, 5'h02, 0, 1, 0, 1, "R9 byte rd lanes");
    // R2 R3 R4 gating
    run_req(16'h0008, 32'h1111_1111, 3'd2, 1, 0, 5'h00, 0, 0, 0, 1, "R2 debug disabled");
    run_req(16'h0008, 32'h2222_2222, 3'd2, 1, 0, 5'h00, 0, 1, 1, 1, "R3 power down");
    run_req(16'h0008, 32'h3333_3333, 3'd2, 1, 0, 5'h00, 1, 1, 0, 0, "R4 secure refused");
    run_req(16'h0008, 32'h4444_4444, 3'd2, 1, 0, 5'h05, 1, 1, 0, 1, "R4 secure allowed");
    run_req(16'h0008, 32'h0, 3'd2, 0, 0, 5'h05, 0, 1, 0, 0, "R4 nonsecure read");
    // R7 misaligned and oversize
    run_req(16'h0001, 32'h0, 3'd1, 0, 0, 5'h00, 0, 1, 0, 1, "R7 half misaligned");
    run_req(16'h0006, 32'h0, 3'd2, 0, 0, 5'h00, 0, 1, 0, 1, "R7 word misaligned");
    run_req(16'h0000, 32'h0, 3'd3, 0, 0, 5'h00, 0, 1, 0, 1, "R7 oversize");
    // R10 error response
    run_req(16'h0040, 32'h5555_5555, 3'd2, 1, 0, 5'h00, 0, 1, 0, 1, "R10 error write");
    run_req(16'h0042, 32'h0, 3'd1, 0, 1, 5'h00, 0, 1, 0, 1, "R11 pack misaligned");
    // R11 packed runs, with wait states for R9 and R8 hold
    max_wait = 3;
    run_req(16'h0010, 32'h8877_6655, 3'd0, 1, 1, 5'h0A, 0, 1, 0, 1, "R11 pack byte wr");
    run_req(16'h0010, 32'h0, 3'd1, 0, 1, 5'h0A, 0, 1, 0, 1, "R11 pack half rd");
    run_req(16'h0050, 32'h0, 3'd0, 0, 1, 5'h0A, 0, 1, 0, 1, "R11 pack error stops");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [2:0] sz;
      sz = ($urandom % 8 == 7) ? 3'd3 : 3'($urandom % 3);
      a  = AW'($urandom % 64);
      if ($urandom % 8 == 0) a = a | 16'h0040;
      if ($urandom % 4 != 0 && sz < 3'd3) a = a & ~((AW'(1) << sz) - AW'(1));
      run_req(a, $urandom, sz, bit'($urandom % 2), ($urandom % 3 == 0),
              5'($urandom), bit'($urandom % 2), ($urandom % 8 != 0),
              ($urandom % 10 == 0), ($urandom % 4 != 0), "random R1 R12");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule